// File: doc/BRIEF.md
# JTAG Status Readback Checker

This block is a host-side JTAG master that reads a target's 32-bit configuration status register. It is used after a configuration load that failed or looks suspect. One pulse on `start` runs a fixed scan sequence. The sequence first forces the target TAP into Test-Logic-Reset. It then loads the configuration-write instruction and shifts a 64-bit read-request packet (`0x2800E001_00000000`) into the data register. Next it loads the configuration-readback instruction and clocks 32 bits out of TDO. At the end the block reports the captured word, a CRC-error flag, a flag that says whether the word differs from the known-good value, and `done`.

TCK, TMS and TDI are generated from the system clock. A pacer toggles TCK every `HALF_CYC` system cycles. TMS and TDI change only on falling TCK. TDO is sampled on rising TCK.

The sequencer has these states:
- `ST_IDLE`: waits for `start`, then goes to `ST_TLR`.
- `ST_TLR`: five TMS-high clocks, then `ST_RTI`.
- `ST_RTI`: one TMS-low clock, then `ST_SEL_IR`.
- `ST_SEL_IR`: TMS pattern 1,1,0,0 to reach Shift-IR, then `ST_SH_IR`.
- `ST_SH_IR`: the opcode, then `ST_UPD_IR`.
- `ST_UPD_IR`: TMS 1,0 through Update-IR to Run-Test/Idle, then `ST_SEL_DR`.
- `ST_SEL_DR`: TMS 1,0,0 to reach Shift-DR. It goes to `ST_SH_PKT` in the write pass and to `ST_SH_RD` in the read pass.
- `ST_SH_PKT` and `ST_SH_RD`: both continue to `ST_UPD_DR`.
- `ST_UPD_DR`: TMS 1,0 back to Run-Test/Idle. It returns to `ST_SEL_IR` after the write pass and goes to `ST_FINISH` after the read pass.
- `ST_FINISH`: waits for TCK to fall, then returns to `ST_IDLE` and sets `done`.

Top module: `jtag_stat_reader`

## Requirements
- R1: After an accepted `start`, the first five rising TCK edges carry TMS=1 and the sixth carries TMS=0, so the TAP passes through Test-Logic-Reset into Run-Test/Idle from any state.
- R2: The configuration-write opcode `OP_WR` (`IR_LEN` bits) is shifted in Shift-IR least significant bit first. TMS rises with its last bit, and the TAP then goes through Update-IR (TMS=1) to Run-Test/Idle (TMS=0).
- R3: The 64-bit packet `0x2800E001_00000000` is shifted in Shift-DR most significant bit first. TMS is 1 only on its last bit, followed by Update-DR and Run-Test/Idle.
- R4: After the packet, the configuration-read opcode `OP_RD` is loaded in the same way as R2, and the TAP is moved to Shift-DR.
- R5: Exactly 32 rising TCK edges occur in Shift-DR during readback. TDO is sampled on each one, and the first bit sampled becomes `stat_word[31]`.
- R6: `crc_err` equals the last bit sampled (`stat_word[0]`). A value of 1 means the target saw a CRC error.
- R7: `stat_mismatch` is 1 at `done` when `stat_word` differs from `EXPECT` (default `0x00007F5E`). It holds its value until the next accepted `start`, which clears it.
- R8: `done` rises when the sequence completes and stays high until the next accepted `start`. A `start` while `busy` is high is ignored.
- R9: TMS and TDI never change while TCK is high.
- R10: TCK is low whenever `busy` is low. While running, every TCK high and low phase lasts exactly `HALF_CYC` clock cycles.
- R11: When `done` rises, the target TAP rests in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a readback sequence |
| tdo | input | 1 | Serial data from the target |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | Serial data to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, results valid |
| stat_word | output | STAT_W | Captured status word |
| crc_err | output | 1 | Last captured bit (CRC error) |
| stat_mismatch | output | 1 | Captured word differs from EXPECT |

## Verification
The bench builds the block with `HALF_CYC=3`, `IR_LEN=6` and the opcodes `6'b110001` and `6'b001110`. Neither opcode reads the same reversed, so a most-significant-first shift of an opcode is caught. The odd half period lets the bench detect any phase that runs a cycle short or long. A behavioural TAP target starts in Pause-DR with the readback instruction already loaded. This makes the reset walk observable. The target also returns status words that are all ones or zeros at opposite ends (`0x80000000`, `0x00007F5F`), which exposes bit-order and CRC-flag faults.

// File: rtl/jsr_pkg.sv
package jsr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TLR,
        ST_RTI,
        ST_SEL_IR,
        ST_SH_IR,
        ST_UPD_IR,
        ST_SEL_DR,
        ST_SH_PKT,
        ST_SH_RD,
        ST_UPD_DR,
        ST_FINISH
    } seq_state_e;

    localparam int TLR_CLKS    = 5;
    localparam int RTI_CLKS    = 1;
    localparam int SEL_IR_CLKS = 4;
    localparam int SEL_DR_CLKS = 3;
    localparam int UPD_CLKS    = 2;

endpackage

// File: rtl/tck_pacer.sv
module tck_pacer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             tck_q;
    logic             at_end;

    always_comb begin
        at_end   = (cnt_q == CNT_W'(HALF_CYC - 1));
        rise_evt = run && at_end && !tck_q;
        fall_evt = run && at_end && tck_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (at_end) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tck = tck_q;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import jsr_pkg::*;
#(
    parameter int            IR_LEN  = 5,
    parameter int            PKT_LEN = 64,
    parameter int            STAT_W  = 32,
    parameter logic [IR_LEN-1:0]  OP_WR = 5'b00101,
    parameter logic [IR_LEN-1:0]  OP_RD = 5'b00100,
    parameter logic [PKT_LEN-1:0] PKT   = 64'h2800E001_00000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic tck_lvl,
    output logic run,
    output logic busy,
    output logic tms,
    output logic tdi,
    output logic smp_en,
    output logic start_acc,
    output logic finish,
    output logic done
);
    localparam int MAXL0 = (PKT_LEN > IR_LEN) ? PKT_LEN : IR_LEN;
    localparam int MAXL  = (MAXL0 > STAT_W) ? MAXL0 : STAT_W;
    localparam int CW    = $clog2(MAXL + 1);

    seq_state_e        state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     len;
    logic              rd_ph_q;
    logic              last;
    logic              tms_nx, tdi_nx;
    logic              tms_q, tdi_q, done_q;
    logic [IR_LEN-1:0] opcode;
    int unsigned       bit_idx;

    // Phase length and end-of-phase detection
    always_comb begin
        unique case (state_q)
            ST_TLR:    len = CW'(TLR_CLKS);
            ST_RTI:    len = CW'(RTI_CLKS);
            ST_SEL_IR: len = CW'(SEL_IR_CLKS);
            ST_SH_IR:  len = CW'(IR_LEN);
            ST_UPD_IR: len = CW'(UPD_CLKS);
            ST_SEL_DR: len = CW'(SEL_DR_CLKS);
            ST_SH_PKT: len = CW'(PKT_LEN);
            ST_SH_RD:  len = CW'(STAT_W);
            ST_UPD_DR: len = CW'(UPD_CLKS);
            default:   len = CW'(1);
        endcase
        last = (cnt_q == len - 1'b1);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_TLR;
            ST_TLR:    if (rise_evt && last) state_d = ST_RTI;
            ST_RTI:    if (rise_evt && last) state_d = ST_SEL_IR;
            ST_SEL_IR: if (rise_evt && last) state_d = ST_SH_IR;
            ST_SH_IR:  if (rise_evt && last) state_d = ST_UPD_IR;
            ST_UPD_IR: if (rise_evt && last) state_d = ST_SEL_DR;
            ST_SEL_DR: if (rise_evt && last) state_d = rd_ph_q ? ST_SH_RD : ST_SH_PKT;
            ST_SH_PKT: if (rise_evt && last) state_d = ST_UPD_DR;
            ST_SH_RD:  if (rise_evt && last) state_d = ST_UPD_DR;
            ST_UPD_DR: if (rise_evt && last) state_d = rd_ph_q ? ST_FINISH : ST_SEL_IR;
            ST_FINISH: if (!tck_lvl) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Pin values for the clock that follows the next falling edge
    always_comb begin
        opcode  = rd_ph_q ? OP_RD : OP_WR;
        bit_idx = 32'(cnt_q);
        tms_nx  = 1'b0;
        tdi_nx  = 1'b0;
        unique case (state_q)
            ST_TLR:    tms_nx = 1'b1;
            ST_SEL_IR: tms_nx = (cnt_q < CW'(2));
            ST_SH_IR: begin
                tms_nx = last;
                tdi_nx = opcode[bit_idx];
            end
            ST_UPD_IR: tms_nx = (cnt_q == '0);
            ST_SEL_DR: tms_nx = (cnt_q == '0);
            ST_SH_PKT: begin
                tms_nx = last;
                tdi_nx = PKT[PKT_LEN - 1 - bit_idx];
            end
            ST_SH_RD:  tms_nx = last;
            ST_UPD_DR: tms_nx = (cnt_q == '0);
            default:   tms_nx = 1'b0;
        endcase
    end

    always_comb begin
        start_acc = (state_q == ST_IDLE) && start;
        finish    = (state_q == ST_FINISH) && !tck_lvl;
        smp_en    = rise_evt && (state_q == ST_SH_RD);
        busy      = (state_q != ST_IDLE);
        run       = busy && !((state_q == ST_FINISH) && !tck_lvl);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_ph_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (rise_evt)
                cnt_q <= cnt_q + 1'b1;
            if (start_acc)
                rd_ph_q <= 1'b0;
            else if (state_q == ST_UPD_DR && state_d == ST_SEL_IR)
                rd_ph_q <= 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tms_q  <= 1'b0;
            tdi_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (start_acc) begin
                tms_q <= 1'b1;
                tdi_q <= 1'b0;
            end else if (fall_evt) begin
                tms_q <= tms_nx;
                tdi_q <= tdi_nx;
            end
            if (start_acc)
                done_q <= 1'b0;
            else if (finish)
                done_q <= 1'b1;
        end
    end

    assign tms  = tms_q;
    assign tdi  = tdi_q;
    assign done = done_q;

    // R9
    pins_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_lvl && $past(tck_lvl)) |-> ($stable(tms_q) && $stable(tdi_q)));

    // R1
    tlr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tms_q);

endmodule

// File: rtl/status_capture.sv
module status_capture #(
    parameter int                STAT_W = 32,
    parameter logic [STAT_W-1:0] EXPECT = 32'h00007F5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic              smp_en,
    input  logic              finish,
    input  logic              tdo,
    output logic [STAT_W-1:0] word,
    output logic              crc_err,
    output logic              mismatch
);
    localparam int SCW = $clog2(STAT_W + 1) + 1;

    logic [STAT_W-1:0] sr_q;
    logic              crc_q, mis_q;
    logic [SCW-1:0]    smp_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            crc_q <= 1'b0;
            mis_q <= 1'b0;
        end else begin
            if (smp_en)
                sr_q <= {sr_q[STAT_W-2:0], tdo};
            if (start_acc) begin
                crc_q <= 1'b0;
                mis_q <= 1'b0;
            end else if (finish) begin
                crc_q <= sr_q[0];
                mis_q <= (sr_q != EXPECT);
            end
        end
    end

    // Sample counter kept for the capture-length check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            smp_cnt_q <= '0;
        else if (start_acc)
            smp_cnt_q <= '0;
        else if (smp_en)
            smp_cnt_q <= smp_cnt_q + 1'b1;
    end

    assign word     = sr_q;
    assign crc_err  = crc_q;
    assign mismatch = mis_q;

    // R5
    capture_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (smp_cnt_q == SCW'(STAT_W)));

    // R7
    mismatch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_acc && !finish) |=> $stable(mis_q));

endmodule

// File: rtl/jtag_stat_reader.sv
module jtag_stat_reader
    import jsr_pkg::*;
#(
    parameter int                 HALF_CYC = 2,
    parameter int                 IR_LEN   = 5,
    parameter int                 PKT_LEN  = 64,
    parameter int                 STAT_W   = 32,
    parameter logic [IR_LEN-1:0]  OP_WR    = 5'b00101,
    parameter logic [IR_LEN-1:0]  OP_RD    = 5'b00100,
    parameter logic [PKT_LEN-1:0] PKT      = 64'h2800E001_00000000,
    parameter logic [STAT_W-1:0]  EXPECT   = 32'h00007F5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              busy,
    output logic              done,
    output logic [STAT_W-1:0] stat_word,
    output logic              crc_err,
    output logic              stat_mismatch
);
    logic run, rise_evt, fall_evt;
    logic smp_en, start_acc, finish;

    tck_pacer #(.HALF_CYC(HALF_CYC)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tck      (tck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    seq_ctrl #(
        .IR_LEN  (IR_LEN),
        .PKT_LEN (PKT_LEN),
        .STAT_W  (STAT_W),
        .OP_WR   (OP_WR),
        .OP_RD   (OP_RD),
        .PKT     (PKT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .tck_lvl   (tck),
        .run       (run),
        .busy      (busy),
        .tms       (tms),
        .tdi       (tdi),
        .smp_en    (smp_en),
        .start_acc (start_acc),
        .finish    (finish),
        .done      (done)
    );

    status_capture #(
        .STAT_W (STAT_W),
        .EXPECT (EXPECT)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .smp_en    (smp_en),
        .finish    (finish),
        .tdo       (tdo),
        .word      (stat_word),
        .crc_err   (crc_err),
        .mismatch  (stat_mismatch)
    );

    // R10
    tck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: tb/jtag_stat_reader_tb.sv
module jtag_stat_reader_tb;
    localparam int          HC   = 3;
    localparam int          IRL  = 6;
    localparam logic [5:0]  OPW  = 6'b110001;
    localparam logic [5:0]  OPR  = 6'b001110;
    localparam logic [63:0] PKTV = 64'h2800E001_00000000;
    localparam logic [31:0] EXPV = 32'h00007F5E;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tdo = 1'b0;
    logic tck, tms, tdi, busy, done, crc_err, stat_mismatch;
    logic [31:0] stat_word;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    jtag_stat_reader #(
        .HALF_CYC(HC), .IR_LEN(IRL), .PKT_LEN(64), .STAT_W(32),
        .OP_WR(OPW), .OP_RD(OPR), .PKT(PKTV), .EXPECT(EXPV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
        .stat_word(stat_word), .crc_err(crc_err), .stat_mismatch(stat_mismatch)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural TAP target ----------------
    typedef enum int {T_TLR, T_RTI, T_SDS, T_CDR, T_SDR, T_E1D, T_PDR, T_E2D,
                      T_UDR, T_SIS, T_CIR, T_SIR, T_E1I, T_PIR, T_E2I, T_UIR} tap_e;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR: return m ? T_TLR : T_RTI;
            T_RTI: return m ? T_SDS : T_RTI;
            T_SDS: return m ? T_SIS : T_CDR;
            T_CDR: return m ? T_E1D : T_SDR;
            T_SDR: return m ? T_E1D : T_SDR;
            T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;
            T_E2D: return m ? T_UDR : T_SDR;
            T_UDR: return m ? T_SDS : T_RTI;
            T_SIS: return m ? T_TLR : T_CIR;
            T_CIR: return m ? T_E1I : T_SIR;
            T_SIR: return m ? T_E1I : T_SIR;
            T_E1I: return m ? T_UIR : T_PIR;
            T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_SIR;
            default: return m ? T_SDS : T_RTI;
        endcase
    endfunction

    tap_e        tap = T_PDR;
    logic [5:0]  ir = OPR, ir_sr = '0;
    logic [63:0] wr_sr = '0;
    logic [31:0] rd_sr = '0, status_val = '0;
    bit          tlr_seen = 1'b0;
    logic [5:0]  ir_log[$];
    logic [63:0] pkt_log[$];

    always @(posedge tck) begin
        if (tap == T_TLR) begin tlr_seen = 1'b1; ir = 6'b000001; end
        if (tap == T_CIR) ir_sr = 6'b000001;
        if (tap == T_SIR) ir_sr = {tdi, ir_sr[5:1]};
        if (tap == T_UIR) begin ir = ir_sr; ir_log.push_back(ir_sr); end
        if (tap == T_CDR && ir == OPR) rd_sr = status_val;
        if (tap == T_SDR && ir == OPW) wr_sr = {wr_sr[62:0], tdi};
        if (tap == T_SDR && ir == OPR) rd_sr = {rd_sr[30:0], 1'b0};
        if (tap == T_UDR && ir == OPW) pkt_log.push_back(wr_sr);
        tap = tap_next(tap, tms);
    end

    always @(negedge tck)
        tdo <= (tap == T_SDR && ir == OPR) ? rd_sr[31] : 1'b0;

    // ---------------- reference pin stream ----------------
    bit q_tms[$];
    bit q_tdi[$];

    task automatic push(input bit m, input bit d);
        q_tms.push_back(m);
        q_tdi.push_back(d);
    endtask

    task automatic push_ir(input logic [5:0] op);
        push(1, 0); push(1, 0); push(0, 0); push(0, 0);
        for (int i = 0; i < IRL; i++) push(i == IRL - 1, op[i]);
        push(1, 0); push(0, 0);
        push(1, 0); push(0, 0); push(0, 0);
    endtask

    task automatic build_stream();
        q_tms.delete();
        q_tdi.delete();
        for (int i = 0; i < 5; i++) push(1, 0);
        push(0, 0);
        push_ir(OPW);
        for (int i = 63; i >= 0; i--) push(i == 0, PKTV[i]);
        push(1, 0); push(0, 0);
        push_ir(OPR);
        for (int i = 0; i < 32; i++) push(i == 31, 0);
        push(1, 0); push(0, 0);
    endtask

    // ---------------- per-clock comparison ----------------
    logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;
    int   hp_cnt = 0;
    bit   had_rise = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy) begin
                chk(tck == 1'b0, "R10", "tck idle", 64'(tck), 64'd0);
                had_rise = 1'b0;
            end
            if (tck && prev_tck)
                chk(tms == prev_tms && tdi == prev_tdi, "R9", "pins moved while tck high",
                    64'({tms, tdi}), 64'({prev_tms, prev_tdi}));
            if (tck != prev_tck) begin
                if (!tck || had_rise)
                    chk(hp_cnt == HC, "R10", "tck half period", 64'(hp_cnt), 64'(HC));
                if (tck) begin
                    had_rise = 1'b1;
                    if (q_tms.size() == 0) begin
                        chk(1'b0, "R1", "unexpected tck rise", 64'd1, 64'd0);
                    end else begin
                        chk(tms == q_tms[0] && tdi == q_tdi[0], "R2",
                            "tms/tdi stream vs reference", 64'({tms, tdi}),
                            64'({q_tms[0], q_tdi[0]}));
                        void'(q_tms.pop_front());
                        void'(q_tdi.pop_front());
                    end
                end
                hp_cnt = 1;
            end else begin
                hp_cnt++;
            end
            prev_tck = tck;
            prev_tms = tms;
            prev_tdi = tdi;
        end
    end

    // ---------------- one readback run ----------------
    task automatic run_once(input logic [31:0] sv, input bit exp_crc,
                            input bit exp_mis, input bit glitch);
        status_val = sv;
        tlr_seen   = 1'b0;
        ir_log.delete();
        pkt_log.delete();
        build_stream();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R8", "done cleared by start", 64'(done), 64'd0);
        chk(stat_mismatch == 1'b0, "R7", "mismatch cleared by start", 64'(stat_mismatch), 64'd0);
        if (glitch) begin
            repeat (200) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(q_tms.size() == 0, "R4", "reference stream fully consumed", 64'(q_tms.size()), 64'd0);
        chk(tlr_seen, "R1", "target visited Test-Logic-Reset", 64'(tlr_seen), 64'd1);
        chk(ir_log.size() == 2, "R4", "instruction loads", 64'(ir_log.size()), 64'd2);
        if (ir_log.size() == 2) begin
            chk(ir_log[0] == OPW, "R2", "first instruction", 64'(ir_log[0]), 64'(OPW));
            chk(ir_log[1] == OPR, "R4", "second instruction", 64'(ir_log[1]), 64'(OPR));
        end
        chk(pkt_log.size() == 1, "R3", "packet updates", 64'(pkt_log.size()), 64'd1);
        if (pkt_log.size() == 1)
            chk(pkt_log[0] == PKTV, "R3", "packet content", pkt_log[0], PKTV);
        chk(stat_word == sv, "R5", "captured word", 64'(stat_word), 64'(sv));
        chk(crc_err == exp_crc, "R6", "crc flag", 64'(crc_err), 64'(exp_crc));
        chk(stat_mismatch == exp_mis, "R7", "mismatch flag", 64'(stat_mismatch), 64'(exp_mis));
        chk(tap == T_RTI, "R11", "target rests in Run-Test/Idle", 64'(tap), 64'(T_RTI));
        chk(busy == 1'b0, "R8", "busy low at done", 64'(busy), 64'd0);
        repeat (25) @(negedge clk);
        chk(done == 1'b1, "R8", "done held", 64'(done), 64'd1);
        chk(stat_mismatch == exp_mis, "R7", "mismatch held", 64'(stat_mismatch), 64'(exp_mis));
        chk(stat_word == sv, "R5", "word held", 64'(stat_word), 64'(sv));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tck == 1'b0 && tms == 1'b0 && tdi == 1'b0, "R10", "pins in reset",
            64'({tck, tms, tdi}), 64'd0);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done/busy in reset", 64'({done, busy}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(stat_mismatch == 1'b0 && crc_err == 1'b0, "R7", "flags after reset",
            64'({stat_mismatch, crc_err}), 64'd0);
        run_once(EXPV, 1'b0, 1'b0, 1'b0);
        run_once(32'h00007F5F, 1'b1, 1'b1, 1'b0);
        run_once(32'h80000000, 1'b0, 1'b1, 1'b1);
        run_once(EXPV, 1'b0, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule